// File: doc/BRIEF.md
# D-PHY Clock Lane Sequencer

This block drives the clock lane of a D-PHY transmitter. In low-power stop the lane holds LP-11. When a high-speed clock is requested, the block steps the lane through the low-power entry states and a zero period. It then starts the toggling DDR clock. A separate pre count must elapse before the block tells the data lanes that they may begin. When the request is withdrawn, the block waits for the data lanes to finish. It keeps the clock toggling for the post count, which is meant to be programmed as clock-post plus data-lane trail time. It then drives HS-0 for the trail count and returns the lane to stop.

All durations are 8-bit counts of byte-clock cycles. They come from a packed clock timing word, a separate pre count and an LPX count. Software may override the lane's HS and LP driver enables individually. A power-down input parks the lane with both drivers off. A soft reset returns the lane to stop with its timer cleared. The DDR clock generator and the analog drivers sit outside this block and are steered by its outputs.

Top module: `dphy_clk_lane_seq`

## Requirements
- R1: After reset and in stop, the lane drives lp_p=1, lp_n=1, tx_lp_en=1, tx_hs_en=0, hs_toggle=0, clk_ready=0.
- R2: A request seen in stop produces LP-01 (lp_p=0, lp_n=1) for lpx_cnt cycles, then LP-00 for clk_tim[31:24] cycles, then HS-0 (tx_hs_en=1, tx_lp_en=0, hs_toggle=0) for clk_tim[23:16] cycles.
- R3: After HS-0 the clock toggles (hs_toggle=1). clk_ready rises pre_cnt cycles later and stays high while the lane is active.
- R4: A duration field of zero lasts one cycle.
- R5: While active, the lane stays active with clk_ready=1 until the request is low and data_done is high in the same cycle.
- R6: On exit, the clock keeps toggling (clk_ready=0) for clk_tim[15:8] cycles. The lane then drives HS-0 for clk_tim[7:0] cycles and returns to stop.
- R7: lane_status is {bias_ok, stop, 0, hs_active}. Bit 3 follows bias_ok. Bit 2 is 1 in stop. Bit 1 is always 0. Bit 0 is 1 in every state with the HS driver enabled.
- R8: When ovr_hs_sel=1, tx_hs_en equals ovr_hs_val. When ovr_lp_sel=1, tx_lp_en equals ovr_lp_val. Neither override changes the sequence or lane_status.
- R9: A soft_rst seen at a clock edge puts the lane in stop from that edge. The timer is cleared, so the next sequence has full durations.
- R10: While pwr_down is high, both enables are 0, lp lines read 11, the lane is held in stop and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous lane reset |
| pwr_down | input | 1 | Lane and PHY power-down |
| hs_req | input | 1 | High-speed clock request |
| data_done | input | 1 | Data lanes finished their HS burst |
| bias_ok | input | 1 | Analog bias ready, reported in status |
| lpx_cnt | input | 8 | LP-01 duration |
| clk_tim | input | 32 | {prepare, zero, post, trail} durations |
| pre_cnt | input | 8 | Toggle cycles before clk_ready |
| ovr_hs_sel | input | 1 | HS enable override select |
| ovr_hs_val | input | 1 | HS enable override value |
| ovr_lp_sel | input | 1 | LP enable override select |
| ovr_lp_val | input | 1 | LP enable override value |
| tx_hs_en | output | 1 | HS driver enable |
| tx_lp_en | output | 1 | LP driver enable |
| lp_p | output | 1 | LP level, positive line |
| lp_n | output | 1 | LP level, negative line |
| hs_toggle | output | 1 | DDR clock toggling enable |
| clk_ready | output | 1 | Data lanes may start |
| lane_status | output | 4 | {bias_ok, stop, 0, hs_active} |

## Verification
Every lane output decodes the state register directly, so a state change is visible right after the edge that causes it. The state after the edge that samples a request is LP-01. Each later phase boundary lies max(field,1) edges further on. The bench adds up these counts and checks every cycle at the falling edge. The exit phases are timed from the edge that first sees data_done high with the request low. Soft reset and power-down act one edge after they are driven. The overrides are combinational and are checked in the same half cycle.

// File: rtl/dphy_clk_pkg.sv
package dphy_clk_pkg;

  typedef enum logic [2:0] {
    CL_STOP  = 3'd0,
    CL_LP01  = 3'd1,
    CL_LP00  = 3'd2,
    CL_HS0   = 3'd3,
    CL_PRE   = 3'd4,
    CL_ACT   = 3'd5,
    CL_POST  = 3'd6,
    CL_TRAIL = 3'd7
  } cl_state_e;

  typedef struct packed {
    logic hs_en;
    logic lp_en;
    logic lp_p;
    logic lp_n;
    logic toggle;
    logic ready;
  } cl_drive_t;

  // Driver pattern of every sequencer state.
  function automatic cl_drive_t drive_of(input cl_state_e s);
    cl_drive_t d;
    d = '{hs_en: 1'b0, lp_en: 1'b1, lp_p: 1'b1, lp_n: 1'b1,
          toggle: 1'b0, ready: 1'b0};
    case (s)
      CL_LP01:          d.lp_p = 1'b0;
      CL_LP00:          begin d.lp_p = 1'b0; d.lp_n = 1'b0; end
      CL_HS0, CL_TRAIL: d = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      CL_PRE, CL_POST:  d = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      CL_ACT:           d = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
      default:          ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cl_phase_timer.sv
module cl_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  // A phase ends on its limit-th cycle; a zero limit still takes one.
  function automatic logic reached(input logic [CNT_W-1:0] c,
                                   input logic [CNT_W-1:0] l);
    return ({1'b0, c} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, l};
  endfunction

  assign expired = reached(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cl_lane_drive.sv
module cl_lane_drive
  import dphy_clk_pkg::*;
(
  input  cl_state_e  state,
  input  logic       pwr_down,
  input  logic       bias_ok,
  input  logic       ovr_hs_sel,
  input  logic       ovr_hs_val,
  input  logic       ovr_lp_sel,
  input  logic       ovr_lp_val,
  output logic       tx_hs_en,
  output logic       tx_lp_en,
  output logic       lp_p,
  output logic       lp_n,
  output logic       hs_toggle,
  output logic       clk_ready,
  output logic [3:0] lane_status,
  output logic       fsm_hs_en
);

  cl_drive_t d;

  assign d         = drive_of(state);
  assign fsm_hs_en = d.hs_en;
  assign lp_p      = d.lp_p;
  assign lp_n      = d.lp_n;
  assign hs_toggle = d.toggle;
  assign clk_ready = d.ready;

  always_comb begin
    if (pwr_down) begin
      tx_hs_en = 1'b0;
      tx_lp_en = 1'b0;
    end else begin
      tx_hs_en = ovr_hs_sel ? ovr_hs_val : d.hs_en;
      tx_lp_en = ovr_lp_sel ? ovr_lp_val : d.lp_en;
    end
  end

  assign lane_status = {bias_ok, state == CL_STOP, 1'b0, d.hs_en};

endmodule

// File: rtl/dphy_clk_lane_seq.sv
module dphy_clk_lane_seq
  import dphy_clk_pkg::*;
#(
  parameter  int CNT_W = 8,
  localparam int TIM_W = 4 * CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             pwr_down,
  input  logic             hs_req,
  input  logic             data_done,
  input  logic             bias_ok,
  input  logic [CNT_W-1:0] lpx_cnt,
  input  logic [TIM_W-1:0] clk_tim,
  input  logic [CNT_W-1:0] pre_cnt,
  input  logic             ovr_hs_sel,
  input  logic             ovr_hs_val,
  input  logic             ovr_lp_sel,
  input  logic             ovr_lp_val,
  output logic             tx_hs_en,
  output logic             tx_lp_en,
  output logic             lp_p,
  output logic             lp_n,
  output logic             hs_toggle,
  output logic             clk_ready,
  output logic [3:0]       lane_status
);

  // Field positions inside the clock timing word (high to low).
  localparam int PREP_HI  = 4 * CNT_W - 1;
  localparam int ZERO_HI  = 3 * CNT_W - 1;
  localparam int POST_HI  = 2 * CNT_W - 1;
  localparam int TRAIL_HI = CNT_W - 1;

  cl_state_e        state, nxt;
  logic [CNT_W-1:0] limit;
  logic             expired;
  logic             lane_clr;
  logic             fsm_hs_en;

  // Duration of the current timed phase.
  always_comb begin
    case (state)
      CL_LP01:  limit = lpx_cnt;
      CL_LP00:  limit = clk_tim[PREP_HI  -: CNT_W];
      CL_HS0:   limit = clk_tim[ZERO_HI  -: CNT_W];
      CL_PRE:   limit = pre_cnt;
      CL_POST:  limit = clk_tim[POST_HI  -: CNT_W];
      CL_TRAIL: limit = clk_tim[TRAIL_HI -: CNT_W];
      default:  limit = '0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      CL_STOP:  if (hs_req)                nxt = CL_LP01;
      CL_LP01:  if (expired)               nxt = CL_LP00;
      CL_LP00:  if (expired)               nxt = CL_HS0;
      CL_HS0:   if (expired)               nxt = CL_PRE;
      CL_PRE:   if (expired)               nxt = CL_ACT;
      CL_ACT:   if (!hs_req && data_done)  nxt = CL_POST;
      CL_POST:  if (expired)               nxt = CL_TRAIL;
      CL_TRAIL: if (expired)               nxt = CL_STOP;
      default:                             nxt = CL_STOP;
    endcase
    if (soft_rst || pwr_down) nxt = CL_STOP;
  end

  assign lane_clr = (nxt != state) || soft_rst || pwr_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CL_STOP;
    else        state <= nxt;
  end

  cl_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (lane_clr),
    .limit   (limit),
    .expired (expired)
  );

  cl_lane_drive u_drive (
    .state       (state),
    .pwr_down    (pwr_down),
    .bias_ok     (bias_ok),
    .ovr_hs_sel  (ovr_hs_sel),
    .ovr_hs_val  (ovr_hs_val),
    .ovr_lp_sel  (ovr_lp_sel),
    .ovr_lp_val  (ovr_lp_val),
    .tx_hs_en    (tx_hs_en),
    .tx_lp_en    (tx_lp_en),
    .lp_p        (lp_p),
    .lp_n        (lp_n),
    .hs_toggle   (hs_toggle),
    .clk_ready   (clk_ready),
    .lane_status (lane_status),
    .fsm_hs_en   (fsm_hs_en)
  );

endmodule

// File: rtl/dphy_clk_lane_chk.sv
module dphy_clk_lane_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic pwr_down,
  input logic data_done,
  input logic ovr_hs_sel,
  input logic ovr_lp_sel,
  input logic tx_hs_en,
  input logic tx_lp_en,
  input logic lp_p,
  input logic lp_n,
  input logic hs_toggle,
  input logic clk_ready,
  input logic lane_stop,
  input logic fsm_hs_en
);

  p_stop_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lane_stop |-> (lp_p && lp_n));

  p_no_dual_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_hs_sel && !ovr_lp_sel) |-> !(tx_hs_en && tx_lp_en));

  p_toggle_after_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_toggle) |-> $past(fsm_hs_en));

  p_ready_toggles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ready |-> hs_toggle);

  p_hold_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ready && !data_done && !soft_rst && !pwr_down) |=> clk_ready);

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (lane_stop && !hs_toggle && !clk_ready));

  p_pd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!tx_hs_en && !tx_lp_en));

  p_pd_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> lane_stop);

endmodule

bind dphy_clk_lane_seq dphy_clk_lane_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .pwr_down   (pwr_down),
  .data_done  (data_done),
  .ovr_hs_sel (ovr_hs_sel),
  .ovr_lp_sel (ovr_lp_sel),
  .tx_hs_en   (tx_hs_en),
  .tx_lp_en   (tx_lp_en),
  .lp_p       (lp_p),
  .lp_n       (lp_n),
  .hs_toggle  (hs_toggle),
  .clk_ready  (clk_ready),
  .lane_stop  (lane_status[2]),
  .fsm_hs_en  (fsm_hs_en)
);

// File: tb/dphy_clk_lane_seq_bench.sv
`timescale 1ns/1ps
module dphy_clk_lane_seq_bench;

  localparam int PH_STOP = 0, PH_LP01 = 1, PH_LP00 = 2, PH_HS0 = 3,
                 PH_PRE = 4, PH_ACT = 5, PH_POST = 6, PH_TRAIL = 7,
                 PH_PD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, pwr_down = 0, hs_req = 0, data_done = 0, bias_ok = 1;
  logic [7:0]  lpx_cnt = 8'd1, pre_cnt = 8'd1;
  logic [31:0] clk_tim = 32'h01010101;
  logic ovr_hs_sel = 0, ovr_hs_val = 0, ovr_lp_sel = 0, ovr_lp_val = 0;
  logic tx_hs_en, tx_lp_en, lp_p, lp_n, hs_toggle, clk_ready;
  logic [3:0] lane_status;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  dphy_clk_lane_seq u_dphy_clk_lane_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pwr_down(pwr_down),
    .hs_req(hs_req), .data_done(data_done), .bias_ok(bias_ok),
    .lpx_cnt(lpx_cnt), .clk_tim(clk_tim), .pre_cnt(pre_cnt),
    .ovr_hs_sel(ovr_hs_sel), .ovr_hs_val(ovr_hs_val),
    .ovr_lp_sel(ovr_lp_sel), .ovr_lp_val(ovr_lp_val),
    .tx_hs_en(tx_hs_en), .tx_lp_en(tx_lp_en), .lp_p(lp_p), .lp_n(lp_n),
    .hs_toggle(hs_toggle), .clk_ready(clk_ready), .lane_status(lane_status)
  );

  wire [7:0] dsig = {tx_hs_en, tx_lp_en, lp_p, lp_n, hs_toggle, clk_ready,
                     lane_status[2], lane_status[0]};

  // {hs_en, lp_en, lp_p, lp_n, toggle, ready, stop, hs_active}
  function automatic logic [7:0] sig_of(int ph);
    case (ph)
      PH_STOP:           return 8'b0111_0010;
      PH_LP01:           return 8'b0101_0000;
      PH_LP00:           return 8'b0100_0000;
      PH_HS0, PH_TRAIL:  return 8'b1000_0001;
      PH_PRE, PH_POST:   return 8'b1000_1001;
      PH_ACT:            return 8'b1000_1101;
      default:           return 8'b0011_0010;
    endcase
  endfunction

  function automatic int at_least1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic run_seq(int l, int p, int z, int r, int po, int tr,
                         string te, string tx);
    int b1, b2, b3, b4, bo, bt, ph;
    @(negedge clk);
    lpx_cnt = 8'(l);
    pre_cnt = 8'(r);
    clk_tim = {8'(p), 8'(z), 8'(po), 8'(tr)};
    hs_req  = 1'b1;
    b1 = at_least1(l);
    b2 = b1 + at_least1(p);
    b3 = b2 + at_least1(z);
    b4 = b3 + at_least1(r);
    @(posedge clk);
    for (int c = 0; c <= b4; c++) begin
      @(negedge clk);
      ph = (c < b1) ? PH_LP01 : (c < b2) ? PH_LP00 :
           (c < b3) ? PH_HS0  : (c < b4) ? PH_PRE  : PH_ACT;
      chk(te, dsig, sig_of(ph));
    end
    hs_req = 1'b0;
    data_done = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R5", dsig, sig_of(PH_ACT));
    end
    data_done = 1'b1;
    bo = at_least1(po);
    bt = bo + at_least1(tr);
    for (int c = 0; c <= bt; c++) begin
      @(negedge clk);
      ph = (c < bo) ? PH_POST : (c < bt) ? PH_TRAIL : PH_STOP;
      chk(tx, dsig, sig_of(ph));
    end
    data_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", dsig, sig_of(PH_STOP));
    chk("R7", {4'd0, lane_status}, 8'b0000_1100);
    bias_ok = 1'b0;
    #1 chk("R7", {4'd0, lane_status}, 8'b0000_0100);
    bias_ok = 1'b1;

    // R8: overrides act on the enables only
    @(negedge clk);
    ovr_hs_sel = 1'b1; ovr_hs_val = 1'b1;
    #1 chk("R8", {6'd0, tx_hs_en, lane_status[2]}, 8'b11);
    ovr_lp_sel = 1'b1; ovr_lp_val = 1'b0;
    #1 chk("R8", {6'd0, tx_lp_en, lane_status[0]}, 8'b00);
    @(negedge clk);
    ovr_hs_sel = 1'b0; ovr_lp_sel = 1'b0; ovr_hs_val = 1'b0;
    #1 chk("R8", dsig, sig_of(PH_STOP));

    // R2 R3 R6 sweep of all fields over 0..2
    for (int l = 0; l < 3; l++)
      for (int p = 0; p < 3; p++)
        for (int z = 0; z < 3; z++)
          for (int r = 0; r < 3; r++)
            for (int po = 0; po < 3; po++)
              for (int tr = 0; tr < 3; tr++)
                run_seq(l, p, z, r, po, tr, "R2 R3", "R6");

    run_seq(0, 0, 0, 0, 0, 0, "R4", "R4");
    run_seq(6, 5, 4, 7, 3, 9, "R2 R3", "R6");

    // R9: soft reset in the middle of entry
    @(negedge clk);
    lpx_cnt = 8'd5; pre_cnt = 8'd5; clk_tim = 32'h05050505; hs_req = 1'b1;
    repeat (8) @(negedge clk);
    soft_rst = 1'b1; hs_req = 1'b0;
    @(negedge clk);
    chk("R9", dsig, sig_of(PH_STOP));
    soft_rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R9", dsig, sig_of(PH_STOP));
    end
    run_seq(3, 1, 2, 1, 2, 1, "R9", "R9");

    // R10: power-down holds the lane parked
    @(negedge clk);
    pwr_down = 1'b1; hs_req = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R10", dsig, sig_of(PH_PD));
    end
    pwr_down = 1'b0; hs_req = 1'b0;
    @(negedge clk);
    chk("R10", dsig, sig_of(PH_STOP));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule